// File: doc/BRIEF.md
# I2C Line Input Conditioner and Output Hold Sequencer

This block sits between the two raw, asynchronous wires of a two-wire serial bus and the protocol logic of a slave that runs on a much faster system clock. Each wire is brought into the clock domain through a two-stage synchronizer. A counting filter follows, and it accepts a new level only after the level has persisted for a programmable number of clock cycles. Shorter pulses are discarded and leave no trace on the clean levels or on any strobe.

From the clean levels the block derives one-cycle strobes for clock rising and falling edges and for the two framing conditions. A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. It also keeps a flag that tells whether the bus is free. On the output side it takes the slave's request to pull the data line low. It lets that request reach the pull-down only while the clean clock is low, and only once a hold delay has elapsed after the clock fell. A change of the slave's own output therefore cannot be mistaken for a framing condition on the bus.

Both delays are parameters in system clock cycles. By default they are computed from a clock frequency parameter, for roughly 50 ns of spike rejection and 300 ns of output hold.

Top module: `i2c_line_conditioner`

## Requirements
- R1: While reset is asserted and right after it is released, both clean levels read 1, all strobes read 0, the bus-free flag reads 1 and the pull-down output reads 0.
- R2: A raw level change that persists reaches its clean level output exactly SPIKE_CYC+2 rising clock edges after it is applied, counting the edge that first samples it.
- R3: A raw pulse that lasts SPIKE_CYC-1 cycles changes neither clean level nor any strobe; a pulse that lasts exactly SPIKE_CYC cycles is passed through.
- R4: The clock rise and clock fall strobes are high for exactly one cycle, which is the first cycle in which the clean clock level shows its new value.
- R5: The data clean level falling while the clean clock level is high and stays high raises the start strobe for exactly one cycle, which is the cycle in which the new data level first shows.
- R6: The data clean level rising while the clean clock level is high and stays high raises the stop strobe for exactly one cycle.
- R7: Data level changes while the clean clock level is low raise neither the start strobe nor the stop strobe.
- R8: The bus-free flag drops in the cycle after a start strobe and rises in the cycle after a stop strobe; other activity leaves it unchanged.
- R9: With the pull request held at 1 while the clock is high, the pull-down output (1 = pull the data line low) rises exactly HOLD_CYC+1 edges after the clean clock level falls. Once that window has passed and the clock stays low, the output follows a request change on the next edge.
- R10: While the clean clock level is high, the pull-down output does not change, whatever the request does.
- R11: Both raw lines changing in the same cycle, whether both falling or both rising, raises neither the start strobe nor the stop strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw | input | 1 | Raw bus clock wire, asynchronous |
| sda_raw | input | 1 | Raw bus data wire, asynchronous |
| pull_req | input | 1 | Slave logic request to pull the data wire low |
| scl_lvl | output | 1 | Clean bus clock level |
| sda_lvl | output | 1 | Clean bus data level |
| scl_rise | output | 1 | One-cycle strobe on clean clock rising |
| scl_fall | output | 1 | One-cycle strobe on clean clock falling |
| start_stb | output | 1 | One-cycle start condition strobe |
| stop_stb | output | 1 | One-cycle stop condition strobe |
| bus_free | output | 1 | High between a stop (or reset) and the next start |
| sda_pull | output | 1 | Sequenced pull-down enable for the data wire |

## Verification
The clean-level path is tried with pulses one cycle shorter than the filter width, exactly at the width and well beyond it. This separates rejection from acceptance and pins the latency to the cycle. The event logic is fed data edges under a high clock, data edges under a low clock and both lines moving together, so that real framing conditions are kept apart from ordinary data and from coincident transitions. The output sequencer gets a request raised during a high clock and then a falling clock, which measures the hold distance exactly. A request change deep inside the low phase then shows the output following without delay.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;

  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int NUM_LINES = 2;

  // Cycles of a clock at hz covering at least ns nanoseconds, never below one.
  function automatic int cycles_for_ns(input longint hz, input longint ns);
    longint c;
    c = ((hz / 1000) * ns + 999_999) / 1_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/i2cc_sync.sv
module i2cc_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  // Idle bus level is high, so both stages come out of reset at all ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '1;
      stage2_q <= '1;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;

endmodule

// File: rtl/i2cc_deglitch.sv
module i2cc_deglitch #(
  parameter int SPIKE_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level
);

  localparam int CW = (SPIKE_CYC < 2) ? 1 : $clog2(SPIKE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SPIKE_CYC - 1);

  logic [CW-1:0] run_q, run_n;
  logic          lvl_q, lvl_n;

  // Count consecutive samples that disagree with the held level; flip on the last.
  always_comb begin
    lvl_n = lvl_q;
    run_n = '0;
    if (din != lvl_q) begin
      if (run_q == LAST) begin
        lvl_n = din;
      end else begin
        run_n = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_n;
      run_q <= run_n;
    end
  end

  assign level = lvl_q;

endmodule

// File: rtl/i2cc_event_detect.sv
module i2cc_event_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_stb,
  output logic stop_stb,
  output logic bus_free
);

  logic scl_q, sda_q;
  logic free_q, free_n;

  // Strobes compare the clean level with its value one cycle earlier.
  always_comb begin
    scl_rise  =  scl_lvl & ~scl_q;
    scl_fall  = ~scl_lvl &  scl_q;
    start_stb =  scl_lvl &  scl_q & sda_q & ~sda_lvl;
    stop_stb  =  scl_lvl &  scl_q & ~sda_q & sda_lvl;
  end

  always_comb begin
    free_n = free_q;
    if (stop_stb) begin
      free_n = 1'b1;
    end else if (start_stb) begin
      free_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      free_q <= 1'b1;
    end else begin
      scl_q  <= scl_lvl;
      sda_q  <= sda_lvl;
      free_q <= free_n;
    end
  end

  assign bus_free = free_q;

endmodule

// File: rtl/i2cc_hold_seq.sv
module i2cc_hold_seq #(
  parameter int HOLD_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic scl_fall,
  input  logic pull_req,
  output logic sda_pull
);

  localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] LOAD = HW'(HOLD_CYC - 1);

  logic [HW-1:0] wait_q, wait_n;
  logic          pull_q, pull_n;
  logic          win_open;

  // The window opens once the count started by the fall strobe has run out.
  always_comb begin
    win_open = ~scl_lvl & ~scl_fall & (wait_q == '0);
    wait_n   = wait_q;
    if (scl_fall) begin
      wait_n = LOAD;
    end else if (wait_q != '0) begin
      wait_n = wait_q - 1'b1;
    end
    pull_n = win_open ? pull_req : pull_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      pull_q <= 1'b0;
    end else begin
      wait_q <= wait_n;
      pull_q <= pull_n;
    end
  end

  assign sda_pull = pull_q;

endmodule

// File: rtl/i2c_line_conditioner.sv
module i2c_line_conditioner #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int SPIKE_CYC = i2cc_pkg::cycles_for_ns(longint'(CLK_HZ), 50),
  parameter int HOLD_CYC  = i2cc_pkg::cycles_for_ns(longint'(CLK_HZ), 300)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  input  logic pull_req,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_stb,
  output logic stop_stb,
  output logic bus_free,
  output logic sda_pull
);

  import i2cc_pkg::*;

  logic [NUM_LINES-1:0] raw_v;
  logic [NUM_LINES-1:0] sync_v;
  logic [NUM_LINES-1:0] clean_v;

  assign raw_v[LINE_SCL] = scl_raw;
  assign raw_v[LINE_SDA] = sda_raw;

  i2cc_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_v),
    .q_sync  (sync_v)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
    i2cc_deglitch #(.SPIKE_CYC(SPIKE_CYC)) u_dg (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sync_v[g]),
      .level (clean_v[g])
    );
  end

  assign scl_lvl = clean_v[LINE_SCL];
  assign sda_lvl = clean_v[LINE_SDA];

  i2cc_event_detect u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_stb (start_stb),
    .stop_stb  (stop_stb),
    .bus_free  (bus_free)
  );

  i2cc_hold_seq #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .scl_fall (scl_fall),
    .pull_req (pull_req),
    .sda_pull (sda_pull)
  );

endmodule

// File: rtl/i2cc_checker.sv
module i2cc_checker #(
  parameter int HOLD_CYC = 30
) (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic scl_rise,
  input logic scl_fall,
  input logic start_stb,
  input logic stop_stb,
  input logic bus_free,
  input logic sda_pull
);

  localparam int SW = $clog2(HOLD_CYC + 2);
  localparam logic [SW-1:0] SAT = SW'(HOLD_CYC + 1);

  // Edges elapsed since the end of the last clock-fall strobe cycle.
  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= SAT;
    end else if (scl_fall) begin
      since_q <= SW'(1);
    end else if (since_q != SAT) begin
      since_q <= since_q + 1'b1;
    end
  end

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |=> !scl_rise); // R4

  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> !scl_fall); // R4

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> !start_stb); // R5

  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> !stop_stb); // R6

  AST_START_CLEARS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> !bus_free); // R8

  AST_STOP_SETS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> bus_free); // R8

  AST_PULL_ONLY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_lvl)); // R10

  AST_PULL_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> (int'($past(since_q)) >= HOLD_CYC)); // R9

endmodule

bind i2c_line_conditioner i2cc_checker #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .scl_rise  (scl_rise),
  .scl_fall  (scl_fall),
  .start_stb (start_stb),
  .stop_stb  (stop_stb),
  .bus_free  (bus_free),
  .sda_pull  (sda_pull)
);

// File: tb/sim_i2c_line_conditioner.sv
module sim_i2c_line_conditioner;

  localparam int CLK_PERIOD = 10;
  localparam int SPK = 3;
  localparam int HLD = 5;
  localparam int NVEC = 14;

  // Entry: {scl, sda, cycles[7:0], exp_scl, exp_sda, exp_starts[1:0], exp_stops[1:0], exp_free}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'd12, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0},
    {1'b0, 1'b0, 8'd12, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    {1'b0, 1'b1, 8'd12, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0},
    {1'b1, 1'b1, 8'd12, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0},
    {1'b1, 1'b0, 8'd2,  1'b1, 1'b1, 2'd0, 2'd0, 1'b0},
    {1'b1, 1'b1, 8'd12, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0},
    {1'b0, 1'b1, 8'd12, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0},
    {1'b0, 1'b0, 8'd12, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    {1'b1, 1'b0, 8'd12, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0},
    {1'b1, 1'b1, 8'd12, 1'b1, 1'b1, 2'd0, 2'd1, 1'b1},
    {1'b0, 1'b1, 8'd2,  1'b1, 1'b1, 2'd0, 2'd0, 1'b1},
    {1'b1, 1'b1, 8'd12, 1'b1, 1'b1, 2'd0, 2'd0, 1'b1},
    {1'b0, 1'b0, 8'd12, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1},
    {1'b1, 1'b1, 8'd12, 1'b1, 1'b1, 2'd0, 2'd0, 1'b1}
  };

  logic clk, rst_n, scl_raw, sda_raw, pull_req;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_stb, stop_stb, bus_free, sda_pull;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  i2c_line_conditioner #(.SPIKE_CYC(SPK), .HOLD_CYC(HLD)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
    .pull_req(pull_req), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_stb(start_stb),
    .stop_stb(stop_stb), .bus_free(bus_free), .sda_pull(sda_pull)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int starts, stops, first, first_p, seen;
    rst_n = 1'b0; scl_raw = 1'b1; sda_raw = 1'b1; pull_req = 1'b0;
    idle_cycles(4);
    check("R1 reset scl_lvl", scl_lvl, 1);
    check("R1 reset bus_free", bus_free, 1);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 scl_lvl", scl_lvl, 1);
    check("R1 sda_lvl", sda_lvl, 1);
    check("R1 strobes", {scl_rise, scl_fall, start_stb, stop_stb}, 0);
    check("R1 bus_free", bus_free, 1);
    check("R1 sda_pull", sda_pull, 0);

    // Table walk: R3 R5 R6 R7 R8 R11
    for (int e = 0; e < NVEC; e++) begin
      logic [16:0] v;
      v = VEC[e];
      scl_raw = v[16];
      sda_raw = v[15];
      starts = 0; stops = 0;
      for (int c = 0; c < int'(v[14:7]); c++) begin
        @(negedge clk);
        starts += int'(start_stb);
        stops  += int'(stop_stb);
      end
      check($sformatf("R3/R7/R11 entry %0d scl_lvl", e), scl_lvl, int'(v[6]));
      check($sformatf("R3/R7/R11 entry %0d sda_lvl", e), sda_lvl, int'(v[5]));
      check($sformatf("R5 R7 R11 entry %0d starts", e), starts, int'(v[4:3]));
      check($sformatf("R6 R7 R11 entry %0d stops", e), stops, int'(v[2:1]));
      check($sformatf("R8 entry %0d bus_free", e), bus_free, int'(v[0]));
    end

    // R2 and R5: exact latency of a data fall under a high clock
    sda_raw = 1'b0;
    first = 0; first_p = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (first == 0 && sda_lvl == 1'b0) begin
        first = i;
        check("R5 start with new level", start_stb, 1);
      end else if (first != 0 && first_p == 0) begin
        first_p = 1;
        check("R5 start one cycle", start_stb, 0);
      end
    end
    check("R2 latency sda", first, SPK + 2);
    check("R8 free after start", bus_free, 0);
    sda_raw = 1'b1;
    idle_cycles(12);
    check("R8 free after stop", bus_free, 1);

    // R4: clock fall and rise strobes
    scl_raw = 1'b0;
    first = 0; first_p = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (first == 0 && scl_lvl == 1'b0) begin
        first = i;
        check("R4 fall strobe", scl_fall, 1);
      end else if (first != 0 && first_p == 0) begin
        first_p = 1;
        check("R4 fall one cycle", scl_fall, 0);
      end
    end
    check("R2 latency scl", first, SPK + 2);
    scl_raw = 1'b1;
    first = 0; first_p = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (first == 0 && scl_lvl == 1'b1) begin
        first = i;
        check("R4 rise strobe", scl_rise, 1);
      end else if (first != 0 && first_p == 0) begin
        first_p = 1;
        check("R4 rise one cycle", scl_rise, 0);
      end
    end

    // R3: pulse of exactly SPK accepted, SPK-1 rejected (clock low)
    scl_raw = 1'b0;
    idle_cycles(12);
    sda_raw = 1'b0;
    seen = 0;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      if (i == SPK) sda_raw = 1'b1;
      if (sda_lvl == 1'b0) seen = 1;
    end
    check("R3 pulse of SPK passes", seen, 1);
    sda_raw = 1'b0;
    seen = 0;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      if (i == SPK - 1) sda_raw = 1'b1;
      if (sda_lvl == 1'b0) seen = 1;
    end
    check("R3 pulse of SPK-1 rejected", seen, 0);

    // R10: request while clock high has no effect
    scl_raw = 1'b1;
    idle_cycles(12);
    pull_req = 1'b1;
    idle_cycles(12);
    check("R10 pull held while clock high", sda_pull, 0);

    // R9: hold distance from clean clock fall
    scl_raw = 1'b0;
    first = 0; first_p = 0;
    for (int i = 1; i <= 25; i++) begin
      @(negedge clk);
      if (first == 0 && scl_lvl == 1'b0) first = i;
      if (first_p == 0 && sda_pull == 1'b1) first_p = i;
    end
    check("R9 hold distance", first_p - first, HLD + 1);
    pull_req = 1'b0;
    @(negedge clk);
    check("R9 follow while low", sda_pull, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule